// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-function peripheral controller. It sits on two byte-wide I/O ports: an address port and a data port. After reset the block is locked. Software opens it by writing a four-byte unlock key to the address port. The last byte of the key depends on the base-port strap: 0x55 when the strap selects base 0x2E, and 0xAA when it selects base 0x4E.

While the block is open, a byte written to the address port picks a register index, and the data port then reads or writes that register. Some registers are global: the device-number selector, the UART clock predivide select, the watchdog configuration bytes and the write-only close control. The rest sit in per-device banks, and the device number chooses the bank. Each bank holds an activate byte and a 16-bit I/O base. The GPIO bank adds a power-control byte and the environment-controller bank adds a power-restore byte. Selected bits of these registers drive the block's outputs. Writing the close value to the control register locks the block again.

Top module: `cfg_port_ctrl`

## Requirements
- R1: `cfg_open` rises on the clock edge that accepts the fourth key byte written to the address port (`port_sel`=0). The key is 0x87, 0x01, 0x55 and then a fourth byte, which is 0x55 when `strap_alt`=0 (base 0x2E) and 0xAA when `strap_alt`=1 (base 0x4E).
- R2: A key byte that differs from the expected one returns the detector to waiting for 0x87, and the mismatching byte is not itself checked as a first byte.
- R3: While locked, `rdata` is 0xFF on both ports, and data-port writes change no register.
- R4: While open, an address-port write stores the index, and reading the address port returns it.
- R5: Writing 0x02 to index 0x02 closes the block and clears the index to 0x00. Any other value written there has no effect. Index 0x02 reads as 0x00.
- R6: Index 0x07 holds the device number (LDN_W bits, with the upper bits reading 0). It selects which bank the bank indices reach.
- R7: Bit 0 of index 0x23 drives `uart_clk24` (0 selects 48 MHz, the reset value; 1 selects 24 MHz). The other bits read 0.
- R8: Indices 0x72, 0x73 and 0x74 read back as written. `wdog_armed` is high exactly when any of the three bytes is nonzero.
- R9: In every bank, index 0x30 (activate, bit 0 drives `dev_active[d]`) and indices 0x60/0x61 (I/O base high and low bytes, on `dev_iobase[16d+15:16d]`) read back all 8 bits as written and reset to 0.
- R10: In bank GPIO_LDN (7), index 0x2A bit 7 drives `sb_switch_en` and bit 0 drives `pg_delay`. All 8 bits read back, so a read-modify-write keeps the untouched bits. In any other bank, index 0x2A reads 0 and writes are ignored.
- R11: In bank EC_LDN (4), index 0xF4 bit 6 drives `pulse_gate` and bit 5 drives `psu_on_keep`. All 8 bits read back.
- R12: Register contents survive closing and reopening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base strap: 0 = base 0x2E, 1 = base 0x4E |
| wr_en | input | 1 | Byte write strobe |
| port_sel | input | 1 | 0 = address port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte of the selected port |
| cfg_open | output | 1 | Configuration mode is open |
| uart_clk24 | output | 1 | UART predivide select (1 = 24 MHz) |
| wdog_armed | output | 1 | Watchdog configuration is nonzero |
| dev_active | output | NDEV | Per-device activate bits |
| dev_iobase | output | 16*NDEV | Per-device I/O base addresses |
| sb_switch_en | output | 1 | Standby switch enable for suspend-to-RAM |
| pg_delay | output | 1 | Extra delay before power-good rises |
| pulse_gate | output | 1 | Gate for the extra power-on pulse |
| psu_on_keep | output | 1 | Power-supply-on state after standby power returns |

## Verification
The hardest state to reach is a bank register that is correct only after a long chain of port writes: the key, a device number, an index and then data. A slip at any step lands the value in a different bank. The stimulus runs a seeded random series of device, index and value triples, each sent through the full port sequence, and keeps a bench-side model of every bank. It then sweeps all banks and compares both the readback and the output pins. Directed cases cover partial and wrong keys, the strap-dependent last byte, writes while locked, and read-modify-write of the two power bytes.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   localparam logic [7:0] KEY_B0      = 8'h87;
   localparam logic [7:0] KEY_B1      = 8'h01;
   localparam logic [7:0] KEY_B2      = 8'h55;
   localparam logic [7:0] KEY_LAST_LO = 8'h55;
   localparam logic [7:0] KEY_LAST_HI = 8'hAA;

   localparam logic [7:0] IX_CTRL  = 8'h02;
   localparam logic [7:0] IX_LDN   = 8'h07;
   localparam logic [7:0] IX_CLK   = 8'h23;
   localparam logic [7:0] IX_PWR   = 8'h2A;
   localparam logic [7:0] IX_ACT   = 8'h30;
   localparam logic [7:0] IX_IOH   = 8'h60;
   localparam logic [7:0] IX_IOL   = 8'h61;
   localparam logic [7:0] IX_WDCFG = 8'h72;
   localparam logic [7:0] IX_WDLO  = 8'h73;
   localparam logic [7:0] IX_WDHI  = 8'h74;
   localparam logic [7:0] IX_APC   = 8'hF4;
   localparam logic [7:0] CLOSE_VAL = 8'h02;

   typedef enum logic [1:0] {KS_0, KS_1, KS_2, KS_3} key_st_e;
endpackage

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
   import cfg_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_alt,
   input  logic       addr_wr,
   input  logic [7:0] wbyte,
   input  logic       close_req,
   output logic       open_o
);
   key_st_e    st_q;
   logic [7:0] expect_b;

   always_comb begin
      case (st_q)
         KS_0:    expect_b = KEY_B0;
         KS_1:    expect_b = KEY_B1;
         KS_2:    expect_b = KEY_B2;
         default: expect_b = strap_alt ? KEY_LAST_HI : KEY_LAST_LO;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= KS_0;
         open_o <= 1'b0;
      end else if (open_o) begin
         if (close_req) open_o <= 1'b0;
      end else if (addr_wr) begin
         if (wbyte == expect_b) begin
            if (st_q == KS_3) begin
               open_o <= 1'b1;
               st_q   <= KS_0;
            end else begin
               st_q <= key_st_e'(st_q + 2'd1);
            end
         end else begin
            st_q <= KS_0;
         end
      end
   end

   // R1: the mode opens only on the write that completes the key
   assert_open_after_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(addr_wr && st_q == KS_3));

   // R5: a close request while open locks on the next edge
   assert_close_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (open_o && close_req) |=> !open_o);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import cfg_port_pkg::*;
#(
   parameter int LDN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       idx,
   input  logic [7:0]       wbyte,
   output logic [LDN_W-1:0] ldn_o,
   output logic             clk24_o,
   output logic             wdog_armed_o,
   output logic             close_req_o,
   output logic [7:0]       rd_val
);
   if (LDN_W < 1 || LDN_W > 8) begin : g_bad_ldn_w
      $error("cfg_global_regs: LDN_W must be 1..8");
   end

   logic [7:0] wd_cfg_q, wd_lo_q, wd_hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldn_o    <= '0;
         clk24_o  <= 1'b0;
         wd_cfg_q <= '0;
         wd_lo_q  <= '0;
         wd_hi_q  <= '0;
      end else if (we) begin
         case (idx)
            IX_LDN:   ldn_o    <= wbyte[LDN_W-1:0];
            IX_CLK:   clk24_o  <= wbyte[0];
            IX_WDCFG: wd_cfg_q <= wbyte;
            IX_WDLO:  wd_lo_q  <= wbyte;
            IX_WDHI:  wd_hi_q  <= wbyte;
            default: ;
         endcase
      end
   end

   assign close_req_o  = we && (idx == IX_CTRL) && (wbyte == CLOSE_VAL);
   assign wdog_armed_o = |{wd_cfg_q, wd_lo_q, wd_hi_q};

   always_comb begin
      case (idx)
         IX_LDN:   rd_val = 8'(ldn_o);
         IX_CLK:   rd_val = {7'd0, clk24_o};
         IX_WDCFG: rd_val = wd_cfg_q;
         IX_WDLO:  rd_val = wd_lo_q;
         IX_WDHI:  rd_val = wd_hi_q;
         default:  rd_val = 8'h00;
      endcase
   end

   // R8: the watchdog can only disarm through a zero write
   assert_wdog_off_by_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdog_armed_o) |-> $past(we && wbyte == 8'h00));
endmodule

// File: rtl/cfg_bank_file.sv
module cfg_bank_file
   import cfg_port_pkg::*;
#(
   parameter int NDEV     = 8,
   parameter int LDN_W    = 3,
   parameter int GPIO_LDN = 7,
   parameter int EC_LDN   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [7:0]        idx,
   input  logic [7:0]        wbyte,
   input  logic [LDN_W-1:0]  ldn,
   output logic [7:0]        rd_val,
   output logic [NDEV-1:0]   dev_active,
   output logic [NDEV*16-1:0] dev_iobase,
   output logic              sb_switch_en,
   output logic              pg_delay,
   output logic              pulse_gate,
   output logic              psu_on_keep
);
   if (NDEV < 1 || NDEV > (1 << LDN_W)) begin : g_bad_ndev
      $error("cfg_bank_file: NDEV must fit in LDN_W bits");
   end
   if (GPIO_LDN >= NDEV || EC_LDN >= NDEV || GPIO_LDN == EC_LDN) begin : g_bad_special
      $error("cfg_bank_file: special banks must be distinct and below NDEV");
   end

   logic [NDEV-1:0][7:0] act_q, ioh_q, iol_q;
   logic [7:0] pwr_q, apc_q;
   logic       gpio_sel, ec_sel;

   assign gpio_sel = (ldn == LDN_W'(GPIO_LDN));
   assign ec_sel   = (ldn == LDN_W'(EC_LDN));

   for (genvar d = 0; d < NDEV; d++) begin : g_bank
      logic hit;
      assign hit = we && (ldn == LDN_W'(d));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q[d] <= '0;
            ioh_q[d] <= '0;
            iol_q[d] <= '0;
         end else if (hit) begin
            if (idx == IX_ACT) act_q[d] <= wbyte;
            if (idx == IX_IOH) ioh_q[d] <= wbyte;
            if (idx == IX_IOL) iol_q[d] <= wbyte;
         end
      end
      assign dev_active[d]           = act_q[d][0];
      assign dev_iobase[d*16 +: 16]  = {ioh_q[d], iol_q[d]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q <= '0;
         apc_q <= '0;
      end else if (we) begin
         if (gpio_sel && idx == IX_PWR) pwr_q <= wbyte;
         if (ec_sel && idx == IX_APC)   apc_q <= wbyte;
      end
   end

   assign sb_switch_en = pwr_q[7];
   assign pg_delay     = pwr_q[0];
   assign pulse_gate   = apc_q[6];
   assign psu_on_keep  = apc_q[5];

   always_comb begin
      rd_val = 8'h00;
      for (int d = 0; d < NDEV; d++) begin
         if (ldn == LDN_W'(d)) begin
            case (idx)
               IX_ACT:  rd_val = act_q[d];
               IX_IOH:  rd_val = ioh_q[d];
               IX_IOL:  rd_val = iol_q[d];
               default: ;
            endcase
         end
      end
      if (gpio_sel && idx == IX_PWR) rd_val = pwr_q;
      if (ec_sel && idx == IX_APC)   rd_val = apc_q;
   end

   // R10: the power byte moves only on a write aimed at the GPIO bank
   assert_pwr_gpio_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!gpio_sel || !we) |=> $stable(pwr_q));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
   import cfg_port_pkg::*;
#(
   parameter int NDEV     = 8,
   parameter int LDN_W    = 3,
   parameter int GPIO_LDN = 7,
   parameter int EC_LDN   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strap_alt,
   input  logic               wr_en,
   input  logic               port_sel,
   input  logic [7:0]         wdata,
   output logic [7:0]         rdata,
   output logic               cfg_open,
   output logic               uart_clk24,
   output logic               wdog_armed,
   output logic [NDEV-1:0]    dev_active,
   output logic [NDEV*16-1:0] dev_iobase,
   output logic               sb_switch_en,
   output logic               pg_delay,
   output logic               pulse_gate,
   output logic               psu_on_keep
);
   logic [7:0]       index_q;
   logic [7:0]       g_rd, b_rd;
   logic [LDN_W-1:0] ldn;
   logic             close_req, reg_we, addr_wr;

   assign addr_wr = wr_en && !port_sel;
   assign reg_we  = wr_en && port_sel && cfg_open;

   cfg_key_unlock u_key (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
      .addr_wr(addr_wr), .wbyte(wdata), .close_req(close_req),
      .open_o(cfg_open)
   );

   cfg_global_regs #(.LDN_W(LDN_W)) u_glob (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(index_q), .wbyte(wdata),
      .ldn_o(ldn), .clk24_o(uart_clk24), .wdog_armed_o(wdog_armed),
      .close_req_o(close_req), .rd_val(g_rd)
   );

   cfg_bank_file #(.NDEV(NDEV), .LDN_W(LDN_W), .GPIO_LDN(GPIO_LDN), .EC_LDN(EC_LDN)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(index_q), .wbyte(wdata),
      .ldn(ldn), .rd_val(b_rd), .dev_active(dev_active), .dev_iobase(dev_iobase),
      .sb_switch_en(sb_switch_en), .pg_delay(pg_delay),
      .pulse_gate(pulse_gate), .psu_on_keep(psu_on_keep)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                   index_q <= '0;
      else if (close_req)           index_q <= '0;
      else if (addr_wr && cfg_open) index_q <= wdata;
   end

   always_comb begin
      if (!cfg_open)     rdata = 8'hFF;
      else if (port_sel) rdata = g_rd | b_rd;
      else               rdata = index_q;
   end

   // R3: a data write while locked leaves every bank output unchanged
   assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && !cfg_open) |=> ($stable(dev_active) && $stable(dev_iobase)));

   // R4: while locked the index cannot move except through a close
   assert_index_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && !close_req) |=> $stable(index_q));
endmodule

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
   localparam int NDEV = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap_alt = 1'b0;
   logic wr_en = 1'b0;
   logic port_sel = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic cfg_open, uart_clk24, wdog_armed, sb_switch_en, pg_delay, pulse_gate, psu_on_keep;
   logic [NDEV-1:0] dev_active;
   logic [NDEV*16-1:0] dev_iobase;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] m_act [NDEV];
   logic [7:0] m_ioh [NDEV];
   logic [7:0] m_iol [NDEV];

   always #5 clk = ~clk;

   cfg_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .wr_en(wr_en),
      .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .cfg_open(cfg_open),
      .uart_clk24(uart_clk24), .wdog_armed(wdog_armed), .dev_active(dev_active),
      .dev_iobase(dev_iobase), .sb_switch_en(sb_switch_en), .pg_delay(pg_delay),
      .pulse_gate(pulse_gate), .psu_on_keep(psu_on_keep)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic put(input logic p, input logic [7:0] v);
      @(negedge clk);
      port_sel = p; wdata = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic get(input logic p, output logic [7:0] v);
      port_sel = p;
      #1;
      v = rdata;
   endtask

   task automatic key(input logic [7:0] last);
      put(0, 8'h87); put(0, 8'h01); put(0, 8'h55); put(0, last);
   endtask

   task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
      put(0, ix); put(1, v);
   endtask

   task automatic rreg(input logic [7:0] ix, output logic [7:0] v);
      put(0, ix); get(1, v);
   endtask

   function automatic logic [7:0] pick_idx(input int k);
      return (k == 0) ? 8'h30 : (k == 1) ? 8'h60 : 8'h61;
   endfunction

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20240611));
      for (int d = 0; d < NDEV; d++) begin m_act[d] = 0; m_ioh[d] = 0; m_iol[d] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 reset locked", cfg_open, 0);
      get(1, v); chk("R3 locked data read", v, 8'hFF);
      get(0, v); chk("R3 locked addr read", v, 8'hFF);
      chk("R7 reset 48MHz", uart_clk24, 0);
      chk("R8 reset disarmed", wdog_armed, 0);
      chk("R9 reset active", dev_active, 0);
      chk("R9 reset iobase", dev_iobase[31:0], 0);

      // R2: broken key, then wrong last byte for this strap
      put(0, 8'h87); put(0, 8'h01); put(0, 8'h33); put(0, 8'h55);
      chk("R2 broken key stays locked", cfg_open, 0);
      key(8'hAA);
      chk("R1 wrong last byte for 0x2E", cfg_open, 0);
      put(0, 8'h87); put(0, 8'h55); put(0, 8'h01); put(0, 8'h55);
      chk("R2 out of order", cfg_open, 0);
      key(8'h55);
      chk("R1 open on base 0x2E", cfg_open, 1);

      put(0, 8'h23); get(0, v); chk("R4 index readback", v, 8'h23);
      put(1, 8'hFF); get(1, v); chk("R7 only bit0 kept", v, 8'h01);
      chk("R7 24MHz selected", uart_clk24, 1);

      wreg(8'h72, 8'h40); chk("R8 armed by cfg", wdog_armed, 1);
      wreg(8'h73, 8'h10); wreg(8'h74, 8'h3C);
      rreg(8'h74, v); chk("R8 hi readback", v, 8'h3C);
      wreg(8'h72, 8'h00); wreg(8'h74, 8'h00);
      chk("R8 still armed by lo", wdog_armed, 1);
      wreg(8'h73, 8'h00); chk("R8 all zero disarms", wdog_armed, 0);

      // GPIO bank power byte with read-modify-write
      wreg(8'h07, 8'h07);
      rreg(8'h07, v); chk("R6 ldn readback", v, 8'h07);
      wreg(8'h2A, 8'h80);
      chk("R10 standby switch on", sb_switch_en, 1);
      chk("R10 delay off", pg_delay, 0);
      rreg(8'h2A, v); put(1, v | 8'h01);
      get(1, v); chk("R10 rmw keeps bit7", v, 8'h81);
      chk("R10 delay on", pg_delay, 1);
      wreg(8'h07, 8'h06); rreg(8'h2A, v); chk("R10 other bank reads 0", v, 8'h00);
      put(1, 8'h00); chk("R10 other bank write ignored", sb_switch_en, 1);

      // EC bank
      wreg(8'h07, 8'h04);
      wreg(8'hF4, 8'h60);
      chk("R11 pulse gate", pulse_gate, 1);
      chk("R11 psu keep", psu_on_keep, 1);
      rreg(8'hF4, v); put(1, v | 8'h04);
      get(1, v); chk("R11 rmw readback", v, 8'h64);

      // random bank traffic
      for (int n = 0; n < 60; n++) begin
         int d = $urandom_range(NDEV - 1);
         int k = $urandom_range(2);
         logic [7:0] val = 8'($urandom);
         wreg(8'h07, 8'(d));
         wreg(pick_idx(k), val);
         if (k == 0) m_act[d] = val; else if (k == 1) m_ioh[d] = val; else m_iol[d] = val;
      end
      for (int d = 0; d < NDEV; d++) begin
         wreg(8'h07, 8'(d));
         rreg(8'h30, v); chk("R9 act readback", v, m_act[d]);
         rreg(8'h60, v); chk("R6 ioh bank readback", v, m_ioh[d]);
         rreg(8'h61, v); chk("R9 iol readback", v, m_iol[d]);
         chk("R9 active pin", dev_active[d], m_act[d][0]);
         chk("R9 iobase pin", dev_iobase[d*16 +: 16], {m_ioh[d], m_iol[d]});
      end

      // close handling
      wreg(8'h02, 8'h05); chk("R5 other value keeps open", cfg_open, 1);
      get(1, v); chk("R5 ctrl reads zero", v, 8'h00);
      wreg(8'h07, 8'h00);
      put(0, 8'h30);
      put(0, 8'h02); put(1, 8'h02);
      chk("R5 closed", cfg_open, 0);
      get(1, v); chk("R3 closed data read", v, 8'hFF);
      put(1, 8'h5A);
      chk("R3 locked write ignored pin", dev_active[0], m_act[0][0]);

      // strap change and reopen
      strap_alt = 1'b1;
      key(8'h55); chk("R1 0x55 rejected on 0x4E", cfg_open, 0);
      key(8'hAA); chk("R1 open on base 0x4E", cfg_open, 1);
      get(0, v); chk("R5 index cleared", v, 8'h00);
      rreg(8'h30, v); chk("R3 locked write ignored", v, m_act[0]);
      wreg(8'h07, 8'h07);
      rreg(8'h2A, v); chk("R12 gpio byte kept", v, 8'h81);
      rreg(8'h23, v); chk("R12 clock select kept", v, 8'h01);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule